// File: doc/BRIEF.md
# Management-Event Status Register with SMI Request

This block gathers several platform management events into sticky status bits and drives a system-management interrupt request while any of them is set. The sources are:

- a write-protect monitor on the boot-firmware flash;
- a century rollover detector on the calendar year byte, which runs in a slow, battery-backed clock domain;
- a watchdog-reached-zero pulse;
- strobes for writes to the outbound and inbound mailbox data registers;
- an NMI condition that is redirected to SMI.

Software reads a single status word through a plain register port. It clears causes by writing ones to their bit positions.

The redirected-NMI bit is a read-only mirror. It follows the underlying NMI status. The century bit lives in the slow domain. Clear requests reach it through a toggle handshake, so a cleared century bit reads back as 1 for a short time. Firmware polls the bit until it reads 0 before it leaves its handler.

Top module: `smi_evt_status`

## Requirements
- R1: After bus reset `rst` and slow-domain reset `rtc_rst`, `reg_rdata` reads 0 and `smi_req` is 0.
- R2: The status word `reg_rdata` has the following layout, and bits 6:4 always read 0.
  - bit 8: flash-write violation
  - bit 7: century rollover
  - bit 3: watchdog timeout
  - bit 2: outbound-mailbox write
  - bit 1: inbound-mailbox write
  - bit 0: redirected NMI
- R3: A write with `reg_wr`=1 clears each of bits 8, 3, 2, 1 whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R4: A cycle with `wdt_zero`, `dout_wr` or `din_wr` high sets bit 3, 2 or 1 respectively at the next clock edge. An event in the same cycle as a clear of its bit leaves the bit set.
- R5: Bit 8 sets when `wp_en` goes from 0 to 1 while `wp_lock` is 1. A rise with `wp_lock`=0, or a fall of `wp_en`, does not set it.
- R6: A `flash_wr` strobe while `wp_en`=1 sets bit 8, unless `flash_addr[31:22]` equals the lower-alias tag 10'h3FE. A strobe while `wp_en`=0 does not set bit 8.
- R7: Bit 7 sets when the slow-domain year byte changes from 8'h99 to 8'h00. No other year transition sets it.
- R8: Writing 1 to bit 7 clears it within 3 `rtc_clk` edges plus 2 bus clocks. The bit still reads 1 in the bus cycle after the write. Asserting `rtc_rst` also clears bit 7.
- R9: Bit 0 sets when `nmi_sts` rises while `nmi_redir_en`=1. Writing to bit 0 has no effect on it. Bit 0 reads 0 in the cycle after `nmi_sts` is 0.
- R10: `smi_req` is 1 exactly while at least one status bit reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high bus reset |
| rtc_clk | input | 1 | Slow calendar clock |
| rtc_rst | input | 1 | Synchronous active-high slow-domain reset |
| year_byte | input | 8 | BCD year value, slow domain |
| wp_en | input | 1 | Flash write-protect enable |
| wp_lock | input | 1 | Write-protect lock |
| flash_wr | input | 1 | Flash write attempt strobe |
| flash_addr | input | 32 | Address of the flash write attempt |
| wdt_zero | input | 1 | Watchdog reached zero |
| dout_wr | input | 1 | Outbound mailbox written |
| din_wr | input | 1 | Inbound mailbox written |
| nmi_sts | input | 1 | Underlying NMI status level |
| nmi_redir_en | input | 1 | NMI-to-SMI redirection enable |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 9 | Write data, ones clear |
| reg_rdata | output | 9 | Status word |
| smi_req | output | 1 | SMI request |

## Verification
The bench uses the default parameters. These are a 32-bit flash address, a 10-bit alias tag at bit 22, an 8-bit BCD year and two-stage synchronizers, with a slow clock that is not a multiple of the bus clock.

With a 10-bit tag, all 1024 tag values can be swept, so the alias exclusion is checked against every other address window. With a 9-bit status word, all 512 write patterns can be applied to a fully set register, so write-one-to-clear is checked for every mask, including writes to the read-only and reserved positions.

The unrelated clock periods put the century clear latency at realistic phase offsets.

// File: rtl/smi_evt_pkg.sv
package smi_evt_pkg;

    localparam int STAT_W     = 9;
    localparam int POS_FLASH  = 8;
    localparam int POS_CENT   = 7;
    localparam int POS_WDT    = 3;
    localparam int POS_DOUT   = 2;
    localparam int POS_DIN    = 1;
    localparam int POS_NMI    = 0;

    typedef struct packed {
        logic flash_viol;
        logic century;
        logic wdt_to;
        logic dout_evt;
        logic din_evt;
        logic nmi_redir;
    } evt_status_t;

    function automatic logic [STAT_W-1:0] pack_status(input evt_status_t s);
        logic [STAT_W-1:0] r;
        r            = '0;
        r[POS_FLASH] = s.flash_viol;
        r[POS_CENT]  = s.century;
        r[POS_WDT]   = s.wdt_to;
        r[POS_DOUT]  = s.dout_evt;
        r[POS_DIN]   = s.din_evt;
        r[POS_NMI]   = s.nmi_redir;
        return r;
    endfunction

    function automatic logic any_pending(input evt_status_t s);
        return s.flash_viol | s.century | s.wdt_to |
               s.dout_evt | s.din_evt | s.nmi_redir;
    endfunction

endpackage

// File: rtl/smi_sync.sv
module smi_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[i] <= '0;
            else     chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/smi_bios_guard.sv
module smi_bios_guard #(
    parameter int ADDR_W    = 32,
    parameter int ALIAS_LSB = 22,
    parameter int ALIAS_TAG = 'h3FE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wp_en,
    input  logic              wp_lock,
    input  logic              flash_wr,
    input  logic [ADDR_W-1:0] flash_addr,
    output logic              viol_hit
);
    localparam int TAG_W = ADDR_W - ALIAS_LSB;

    logic             wp_prev_q;
    logic [TAG_W-1:0] tag;
    logic             in_alias;
    logic             lock_arm;
    logic             prot_wr;
    logic [ALIAS_LSB-1:0] addr_low_unused;

    assign tag             = flash_addr[ADDR_W-1:ALIAS_LSB];
    assign addr_low_unused = flash_addr[ALIAS_LSB-1:0];
    assign in_alias        = (tag == TAG_W'(ALIAS_TAG));

    always_ff @(posedge clk) begin
        if (rst) wp_prev_q <= 1'b0;
        else     wp_prev_q <= wp_en;
    end

    assign lock_arm = wp_en & ~wp_prev_q & wp_lock;
    assign prot_wr  = flash_wr & wp_en & ~in_alias;
    assign viol_hit = lock_arm | prot_wr;
endmodule

// File: rtl/smi_cent_slow.sv
module smi_cent_slow #(
    parameter int YEAR_W      = 8,
    parameter int WRAP_HI     = 'h99,
    parameter int SYNC_STAGES = 2
) (
    input  logic              rtc_clk,
    input  logic              rtc_rst,
    input  logic [YEAR_W-1:0] year_byte,
    input  logic              clr_tog,
    output logic              flag
);
    logic [YEAR_W-1:0] year_q;
    logic              tog_s;
    logic              tog_last_q;
    logic              rollover;
    logic              clr_edge;

    smi_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tog_sync (
        .clk (rtc_clk),
        .rst (rtc_rst),
        .d   (clr_tog),
        .q   (tog_s)
    );

    assign rollover = (year_q == YEAR_W'(WRAP_HI)) && (year_byte == '0);
    assign clr_edge = tog_s ^ tog_last_q;

    always_ff @(posedge rtc_clk) begin
        if (rtc_rst) begin
            year_q     <= '0;
            tog_last_q <= 1'b0;
            flag       <= 1'b0;
        end else begin
            year_q     <= year_byte;
            tog_last_q <= tog_s;
            if (rollover)      flag <= 1'b1;
            else if (clr_edge) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/smi_evt_status.sv
module smi_evt_status
    import smi_evt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int ALIAS_LSB   = 22,
    parameter int ALIAS_TAG   = 'h3FE,
    parameter int YEAR_W      = 8,
    parameter int WRAP_HI     = 'h99,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rtc_clk,
    input  logic              rtc_rst,
    input  logic [YEAR_W-1:0] year_byte,
    input  logic              wp_en,
    input  logic              wp_lock,
    input  logic              flash_wr,
    input  logic [ADDR_W-1:0] flash_addr,
    input  logic              wdt_zero,
    input  logic              dout_wr,
    input  logic              din_wr,
    input  logic              nmi_sts,
    input  logic              nmi_redir_en,
    input  logic              reg_wr,
    input  logic [STAT_W-1:0] reg_wdata,
    output logic [STAT_W-1:0] reg_rdata,
    output logic              smi_req
);
    evt_status_t bus_q;
    evt_status_t view;
    logic        viol_hit;
    logic        cent_tog_q;
    logic        cent_slow;
    logic        cent_bus;
    logic        nmi_prev_q;
    logic        clr_flash, clr_cent, clr_wdt, clr_dout, clr_din;
    logic [3:0]  wdata_unused;

    assign clr_flash    = reg_wr & reg_wdata[POS_FLASH];
    assign clr_cent     = reg_wr & reg_wdata[POS_CENT];
    assign clr_wdt      = reg_wr & reg_wdata[POS_WDT];
    assign clr_dout     = reg_wr & reg_wdata[POS_DOUT];
    assign clr_din      = reg_wr & reg_wdata[POS_DIN];
    assign wdata_unused = {reg_wdata[6:4], reg_wdata[POS_NMI]};

    smi_bios_guard #(
        .ADDR_W    (ADDR_W),
        .ALIAS_LSB (ALIAS_LSB),
        .ALIAS_TAG (ALIAS_TAG)
    ) u_guard (
        .clk        (clk),
        .rst        (rst),
        .wp_en      (wp_en),
        .wp_lock    (wp_lock),
        .flash_wr   (flash_wr),
        .flash_addr (flash_addr),
        .viol_hit   (viol_hit)
    );

    smi_cent_slow #(
        .YEAR_W      (YEAR_W),
        .WRAP_HI     (WRAP_HI),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cent (
        .rtc_clk   (rtc_clk),
        .rtc_rst   (rtc_rst),
        .year_byte (year_byte),
        .clr_tog   (cent_tog_q),
        .flag      (cent_slow)
    );

    smi_sync #(.W(1), .STAGES(SYNC_STAGES)) u_cent_sync (
        .clk (clk),
        .rst (rst),
        .d   (cent_slow),
        .q   (cent_bus)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_q      <= '0;
            cent_tog_q <= 1'b0;
            nmi_prev_q <= 1'b0;
        end else begin
            bus_q.flash_viol <= viol_hit | (bus_q.flash_viol & ~clr_flash);
            bus_q.century    <= 1'b0;
            bus_q.wdt_to     <= wdt_zero | (bus_q.wdt_to   & ~clr_wdt);
            bus_q.dout_evt   <= dout_wr  | (bus_q.dout_evt & ~clr_dout);
            bus_q.din_evt    <= din_wr   | (bus_q.din_evt  & ~clr_din);
            bus_q.nmi_redir  <= nmi_sts &
                                (bus_q.nmi_redir | (~nmi_prev_q & nmi_redir_en));
            nmi_prev_q       <= nmi_sts;
            cent_tog_q       <= cent_tog_q ^ clr_cent;
        end
    end

    always_comb begin
        view         = bus_q;
        view.century = cent_bus;
    end

    assign reg_rdata = pack_status(view);
    assign smi_req   = any_pending(view);
endmodule

// File: rtl/smi_evt_status_chk.sv
module smi_evt_status_chk #(
    parameter int ADDR_W    = 32,
    parameter int ALIAS_LSB = 22,
    parameter int ALIAS_TAG = 'h3FE,
    parameter int STAT_W    = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              wp_lock,
    input logic              flash_wr,
    input logic [ADDR_W-1:0] flash_addr,
    input logic              wdt_zero,
    input logic              dout_wr,
    input logic              din_wr,
    input logic              nmi_sts,
    input logic              reg_wr,
    input logic [STAT_W-1:0] reg_wdata,
    input logic [STAT_W-1:0] reg_rdata,
    input logic              smi_req
);
    localparam int TAG_W = ADDR_W - ALIAS_LSB;

    // R4
    wdt_set_chk: assert property (@(posedge clk) disable iff (rst)
        wdt_zero |=> reg_rdata[3]);
    // R4
    dout_set_chk: assert property (@(posedge clk) disable iff (rst)
        dout_wr |=> reg_rdata[2]);
    // R4
    din_set_chk: assert property (@(posedge clk) disable iff (rst)
        din_wr |=> reg_rdata[1]);
    // R3
    wdt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_wdata[3] && !wdt_zero) |=> !reg_rdata[3]);
    // R3
    din_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[1] && !(reg_wr && reg_wdata[1])) |=> reg_rdata[1]);
    // R6
    alias_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (flash_wr && flash_addr[ADDR_W-1:ALIAS_LSB] == TAG_W'(ALIAS_TAG)
         && !wp_lock && !reg_rdata[8]) |=> !reg_rdata[8]);
    // R9
    nmi_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !nmi_sts |=> !reg_rdata[0]);
    // R9
    nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[0] && nmi_sts) |=> reg_rdata[0]);
    // R10
    smi_on_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata != '0) |-> smi_req);
    // R10
    smi_off_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata == '0) |-> !smi_req);
endmodule

bind smi_evt_status smi_evt_status_chk #(
    .ADDR_W    (ADDR_W),
    .ALIAS_LSB (ALIAS_LSB),
    .ALIAS_TAG (ALIAS_TAG),
    .STAT_W    (smi_evt_pkg::STAT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wp_lock    (wp_lock),
    .flash_wr   (flash_wr),
    .flash_addr (flash_addr),
    .wdt_zero   (wdt_zero),
    .dout_wr    (dout_wr),
    .din_wr     (din_wr),
    .nmi_sts    (nmi_sts),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .smi_req    (smi_req)
);

// File: tb/smi_evt_status_tb.sv
module smi_evt_status_tb;
    logic        clk = 1'b0;
    logic        rtc_clk = 1'b0;
    logic        rst = 1'b1;
    logic        rtc_rst = 1'b1;
    logic [7:0]  year_byte = '0;
    logic        wp_en = 0, wp_lock = 0, flash_wr = 0;
    logic [31:0] flash_addr = '0;
    logic        wdt_zero = 0, dout_wr = 0, din_wr = 0;
    logic        nmi_sts = 0, nmi_redir_en = 0;
    logic        reg_wr = 0;
    logic [8:0]  reg_wdata = '0;
    logic [8:0]  reg_rdata;
    logic        smi_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;
    always #37 rtc_clk = ~rtc_clk;

    smi_evt_status u_dut (
        .clk(clk), .rst(rst), .rtc_clk(rtc_clk), .rtc_rst(rtc_rst),
        .year_byte(year_byte), .wp_en(wp_en), .wp_lock(wp_lock),
        .flash_wr(flash_wr), .flash_addr(flash_addr), .wdt_zero(wdt_zero),
        .dout_wr(dout_wr), .din_wr(din_wr), .nmi_sts(nmi_sts),
        .nmi_redir_en(nmi_redir_en), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .smi_req(smi_req)
    );

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [8:0] exp);
        n_chk++;
        if (reg_rdata !== exp || smi_req !== (exp != 0)) begin
            n_bad++;
            $display("FAIL %s: rdata=%h smi=%b expected rdata=%h smi=%b",
                     req, reg_rdata, smi_req, exp, exp != 0);
        end
    endtask

    task automatic wr(input logic [8:0] w);
        reg_wr = 1'b1; reg_wdata = w;
        cyc();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic set_year(input logic [7:0] v);
        @(negedge rtc_clk);
        year_byte = v;
        @(posedge rtc_clk);
        repeat (4) cyc();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge rtc_clk);
        @(negedge rtc_clk) rtc_rst = 1'b0;
        cyc(); rst = 1'b0;
        cyc();
        chk("R1 reset", 9'h000);

        // R4 single events and R2 positions
        wdt_zero = 1; cyc(); wdt_zero = 0; chk("R4/R2 timeout bit3", 9'h008);
        wr(9'h008); chk("R3 clear bit3", 9'h000);
        dout_wr = 1; cyc(); dout_wr = 0; chk("R4/R2 dout bit2", 9'h004);
        wr(9'h004); chk("R3 clear bit2", 9'h000);
        din_wr = 1; cyc(); din_wr = 0; chk("R4/R2 din bit1", 9'h002);
        wr(9'h002); chk("R3 clear bit1", 9'h000);
        // R4 set wins over clear
        wdt_zero = 1; reg_wr = 1; reg_wdata = 9'h008; cyc();
        wdt_zero = 0; reg_wr = 0; reg_wdata = '0;
        chk("R4 set beats clear", 9'h008);
        wr(9'h008);

        // R5 lock-armed rise
        wp_lock = 1; wp_en = 1; cyc(); chk("R5 rise with lock", 9'h100);
        wr(9'h100); chk("R3 clear bit8", 9'h000);
        wp_en = 0; cyc(); chk("R5 fall no set", 9'h000);
        wp_lock = 0; wp_en = 1; cyc(); chk("R5 rise without lock", 9'h000);

        // R6 sweep of every alias tag
        for (int t = 0; t < 1024; t++) begin
            flash_addr = {t[9:0], 22'h0ABCDE};
            flash_wr = 1; cyc(); flash_wr = 0;
            chk("R6 tag sweep", (t == 'h3FE) ? 9'h000 : 9'h100);
            if (reg_rdata != 0) wr(9'h100);
        end
        wp_en = 0; flash_addr = 32'hFFC0_0000;
        flash_wr = 1; cyc(); flash_wr = 0; chk("R6 unprotected write", 9'h000);

        // R9 redirected NMI
        nmi_sts = 1; cyc(); chk("R9 redirection off", 9'h000);
        nmi_sts = 0; cyc();
        nmi_redir_en = 1; nmi_sts = 1; cyc(); chk("R9 set", 9'h001);
        wr(9'h001); chk("R9 write ignored", 9'h001);
        nmi_sts = 0; cyc(); chk("R9 follows nmi", 9'h000);

        // R3 sweep of all write masks over a full register
        wp_en = 1; flash_addr = 32'hFFC0_1000;
        nmi_sts = 1; cyc();
        for (int w = 0; w < 512; w++) begin
            wdt_zero = 1; dout_wr = 1; din_wr = 1; flash_wr = 1; cyc();
            wdt_zero = 0; dout_wr = 0; din_wr = 0; flash_wr = 0;
            chk("R3 full set", 9'h10F);
            wr(w[8:0]);
            chk("R3 mask sweep", 9'h10F & ~(w[8:0] & 9'h17E));
        end
        nmi_sts = 0; wp_en = 0; cyc();
        wr(9'h1FF); chk("R3 all cleared", 9'h000);

        // R10 held until last cause cleared
        wdt_zero = 1; din_wr = 1; cyc(); wdt_zero = 0; din_wr = 0;
        wr(9'h008); chk("R10 one cause left", 9'h002);
        wr(9'h002); chk("R10 none left", 9'h000);

        // R7 century rollover and R8 clear latency
        set_year(8'h98); set_year(8'h99); set_year(8'h00);
        chk("R7 rollover sets", 9'h080);
        wr(9'h080); chk("R8 still set after write", 9'h080);
        repeat (4) @(posedge rtc_clk);
        repeat (3) cyc();
        chk("R8 cleared", 9'h000);
        set_year(8'h99); set_year(8'h01); chk("R7 99 to 01", 9'h000);
        set_year(8'h50); set_year(8'h00); chk("R7 50 to 00", 9'h000);
        set_year(8'h99); set_year(8'h00); chk("R7 second rollover", 9'h080);
        @(negedge rtc_clk) rtc_rst = 1;
        @(negedge rtc_clk) rtc_rst = 0;
        repeat (4) cyc();
        chk("R8 slow reset clears", 9'h000);

        done = 1;
        summary();
    end
endmodule